// File: doc/BRIEF.md
# Negotiation Page Status Flags

This block keeps the two status bits that management software polls while link partners exchange negotiation pages. The negotiation engine reports three events: a page has arrived, that page is the first (base) page of the exchange, and a fresh negotiation has begun. The block turns these events into a sticky page-arrived flag and a base-page flag. Software reads both flags together through a read strobe, and the read clears them.

A mode bit selects how the page-arrived flag treats a restarted negotiation. In normal mode the flag stays set until it is read. In alternate mode the flag is also dropped as soon as a new negotiation starts. Software then cannot read an old flag and take stale partner-ability contents as valid. The base-page flag tells software that the exchange has gone back to its first page, so any next pages have to be sent again.

Top module: `an_page_status`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, page_flag, base_flag and alt_mode are 0. The block therefore leaves reset in normal mode.
- R2: When pg_evt is high at a clock edge, page_flag is 1 after that edge. Without a read or an alternate-mode restart, it then holds at 1.
- R3: rd_data[0] shows page_flag and rd_data[1] shows base_flag, combinationally, in the read cycle. When rd_stb is high at an edge and pg_evt is low, page_flag is 0 after that edge.
- R4: When alt_mode is 1, and restart_evt is high at an edge with pg_evt and rd_stb both low, page_flag is 0 after that edge.
- R5: When alt_mode is 0, restart_evt has no effect on page_flag.
- R6: When pg_evt and base_evt are both high at an edge, base_flag is 1 after that edge. A page event with base_evt low leaves base_flag unchanged.
- R7: When rd_stb is high at an edge and the base-page set condition is absent, base_flag is 0 after that edge. restart_evt never changes base_flag.
- R8: A set condition beats a clear in the same cycle. pg_evt beats both rd_stb and restart_evt for page_flag, and pg_evt with base_evt beats rd_stb for base_flag.
- R9: When cfg_we is high at an edge, alt_mode takes the value of cfg_alt. Otherwise alt_mode holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Loads the mode bit |
| cfg_alt | input | 1 | Mode value to load (1 = alternate) |
| pg_evt | input | 1 | Single-cycle pulse: a page was received |
| base_evt | input | 1 | Qualifies pg_evt: the received page is the base page |
| restart_evt | input | 1 | Single-cycle pulse: a new negotiation started |
| rd_stb | input | 1 | Single-cycle status register read strobe |
| rd_data | output | 2 | Read value: bit 0 page flag, bit 1 base flag |
| page_flag | output | 1 | Sticky page-received flag |
| base_flag | output | 1 | Base-page flag |
| alt_mode | output | 1 | Current mode bit |

## Verification
Directed sequences come first and isolate each path:
- a restart with the mode bit set and then clear, which separates R4 from R5;
- a page event in the same cycle as a read, and in the same cycle as a restart, which exposes the priority in R8;
- a next-page event after a base page, which shows whether base_flag is wrongly touched.

Random cycles with a fixed seed then set events, reads, restarts and mode writes at mixed densities. These reach combinations the directed part skips, such as a read together with a restart. A bench function predicts each flag, and every check is tagged with the rule that decided the expected value.

// File: rtl/an_page_status.sv
module an_page_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic       cfg_alt,
  input  logic       pg_evt,
  input  logic       base_evt,
  input  logic       restart_evt,
  input  logic       rd_stb,
  output logic [1:0] rd_data,
  output logic       page_flag,
  output logic       base_flag,
  output logic       alt_mode
);

  logic page_q, base_q, alt_q;
  logic base_set;

  assign base_set = pg_evt & base_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q <= 1'b0;
      base_q <= 1'b0;
      alt_q  <= 1'b0;
    end else begin
      if (cfg_we) alt_q <= cfg_alt;

      if (pg_evt)                     page_q <= 1'b1;
      else if (rd_stb)                page_q <= 1'b0;
      else if (restart_evt && alt_q)  page_q <= 1'b0;

      if (base_set)    base_q <= 1'b1;
      else if (rd_stb) base_q <= 1'b0;
    end
  end

  assign rd_data   = {base_q, page_q};
  assign page_flag = page_q;
  assign base_flag = base_q;
  assign alt_mode  = alt_q;

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (!page_flag && !base_flag && !alt_mode));

  a_r2_page_set: assert property (@(posedge clk) disable iff (!rst_n)
    pg_evt |=> page_flag);

  a_r3_read_clears_page: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !pg_evt) |=> !page_flag);

  a_r4_alt_restart_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_mode && restart_evt && !pg_evt) |=> !page_flag);

  a_r5_normal_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!alt_mode && !pg_evt && !rd_stb) |=> $stable(page_flag));

  a_r6_base_set: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_evt && base_evt) |=> base_flag);

  a_r7_base_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !(pg_evt && base_evt)) |=> !base_flag);

  a_r7_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stb && !(pg_evt && base_evt)) |=> $stable(base_flag));

  a_r9_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(alt_mode));

endmodule

// File: tb/test_an_page_status.sv
module test_an_page_status;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 0, cfg_alt = 0, pg_evt = 0, base_evt = 0, restart_evt = 0, rd_stb = 0;
  logic [1:0] rd_data;
  logic page_flag, base_flag, alt_mode;

  int total = 0, bad = 0;
  logic m_page = 0, m_base = 0, m_alt = 0;

  always #10 clk = ~clk;

  an_page_status i_an_page_status (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_alt(cfg_alt),
    .pg_evt(pg_evt), .base_evt(base_evt), .restart_evt(restart_evt),
    .rd_stb(rd_stb), .rd_data(rd_data), .page_flag(page_flag),
    .base_flag(base_flag), .alt_mode(alt_mode)
  );

  function automatic logic nxt_page(logic cur, logic alt, logic p, logic r, logic rd);
    if (p) return 1'b1;
    if (rd) return 1'b0;
    if (r && alt) return 1'b0;
    return cur;
  endfunction

  function automatic logic nxt_base(logic cur, logic p, logic b, logic rd);
    if (p && b) return 1'b1;
    if (rd) return 1'b0;
    return cur;
  endfunction

  function automatic string page_tag(logic alt, logic p, logic r, logic rd);
    if (p && (rd || r)) return "R8";
    if (p) return "R2";
    if (rd) return "R3";
    if (r) return alt ? "R4" : "R5";
    return "R2";
  endfunction

  function automatic string base_tag(logic p, logic b, logic rd);
    if (p && b && rd) return "R8";
    if (rd) return "R7";
    return "R6";
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(logic p, logic b, logic r, logic rd, logic we, logic a);
    logic np, nb, na;
    string pt, bt;
    @(negedge clk);
    pg_evt = p; base_evt = b; restart_evt = r; rd_stb = rd; cfg_we = we; cfg_alt = a;
    #1;
    check("R3", "rd_data", int'(rd_data), int'({m_base, m_page}));
    np = nxt_page(m_page, m_alt, p, r, rd);
    nb = nxt_base(m_base, p, b, rd);
    na = we ? a : m_alt;
    pt = page_tag(m_alt, p, r, rd);
    bt = base_tag(p, b, rd);
    @(posedge clk); #1;
    check(pt, "page_flag", int'(page_flag), int'(np));
    check(bt, "base_flag", int'(base_flag), int'(nb));
    check("R9", "alt_mode", int'(alt_mode), int'(na));
    m_page = np; m_base = nb; m_alt = na;
  endtask

  initial begin
    #(20 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1;
    check("R1", "page_flag in reset", int'(page_flag), 0);
    check("R1", "base_flag in reset", int'(base_flag), 0);
    check("R1", "alt_mode in reset", int'(alt_mode), 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1", "alt_mode after reset", int'(alt_mode), 0);
    check("R1", "page_flag after reset", int'(page_flag), 0);

    // R5: normal-mode restart keeps the flag
    step(1, 0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    // R3: read returns the old value, then clears
    step(0, 0, 0, 1, 0, 0);
    // R8: page event and read together
    step(1, 1, 0, 1, 0, 0);
    step(0, 0, 0, 1, 0, 0);
    // R9 + R4: alternate-mode restart clears
    step(0, 0, 0, 0, 1, 1);
    step(1, 1, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0);
    // R6: a next page leaves base_flag set
    step(1, 0, 0, 0, 0, 0);
    // R8: page event beats restart
    step(1, 0, 1, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 1, 0);

    for (int i = 0; i < 3000; i++) begin
      int dens;
      dens = (i < 1500) ? 4 : 2;
      step(($urandom % dens) == 0, $urandom % 2, ($urandom % dens) == 0,
           ($urandom % dens) == 0, ($urandom % 16) == 0, $urandom % 2);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule